// File: doc/BRIEF.md
# SDRAM Bank Timing Guard and Read-Return Scheduler

This block sits in a single-data-rate SDRAM controller. It follows the state of one bank and the shared read-return path. Commands and data run on the same clock, and the block takes at most one command per cycle. For each command it decides whether the command is legal. A command can be illegal because the bank is in the wrong state, because the row-to-column delay has not yet run out since the activate, or because the minimum row-active time has not yet run out before a precharge. An illegal command is dropped and reported with a one-cycle error pulse.

For every accepted read, the block works out when the data words return on the bus. The first word comes a CAS latency after the command, followed by the rest of a fixed-length burst. In each of those cycles it raises a data-valid strobe together with the column of the word. Reads that arrive back to back are pipelined. A later read takes over the bus from the earlier burst at its own start cycle. A burst-stop command cancels every strobe still to come.

The three timing limits are cycle counts. They are captured while reset is held, so the controller sets them once at initialization.

Top module: `sdram_bank_sched`

## Requirements
- R1: While `rstN` is low, the block captures `cfgRcd`, `cfgRas` and `cfgCas`, and these values stay in force until the next reset. A row delay of 0 behaves as 1. A CAS value below 2 runs as 2, and a value above 3 runs as 3. Out of reset, `rowOpen`, `rdValid` and `cmdError` are all low.
- R2: `cmdOp` uses these codes: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop. Codes 6 and 7 act as no-ops and never raise an error.
- R3: An activate to a closed bank opens it and sets `openRow` to `cmdRow` from the next cycle on. An activate to an open bank is illegal.
- R4: A read or write issued k cycles after the accepted activate is legal only when k ≥ the row delay.
- R5: A precharge issued k cycles after the accepted activate is legal only when k ≥ the row-active limit. A legal precharge closes the bank from the next cycle on.
- R6: A read, write or precharge to a closed bank is illegal.
- R7: An illegal command drives `cmdError` high for exactly the cycle that follows it and has no other effect. In particular, a rejected read produces no data strobes. Every legal command leaves `cmdError` low.
- R8: When a read is accepted in cycle t, `rdValid` is high in cycles t+CL through t+CL+BL-1 (BL defaults to 2), unless a later read or a burst stop overrides it.
- R9: Beat i of a read to column c reports `rdCol` equal to the BL-aligned base of c plus (c+i) mod BL. The order wraps inside the aligned block, so with BL=2, column 5 returns 5 and then 4.
- R10: A read accepted in cycle t takes over the data bus from cycle t+CL on. Any beats of an earlier burst from that cycle onward are dropped. Reads spaced BL apart therefore deliver bursts end to end.
- R11: A burst stop in cycle t is always legal. It leaves `rdValid` low from cycle t+1 on until a newer read is accepted, and it also cancels reads whose data has not yet started.
- R12: Legal reads and writes leave the bank open and `openRow` unchanged. Writes never raise `rdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by commands and data |
| rstN | input | 1 | Active-low synchronous reset; timing limits are captured while it is low |
| cfgRcd | input | 4 | Row-to-column delay in cycles |
| cfgRas | input | 4 | Minimum row-active time in cycles |
| cfgCas | input | 4 | CAS latency in cycles (2 or 3) |
| cmdOp | input | 3 | Command code for this cycle |
| cmdRow | input | ROW_W | Row address for an activate |
| cmdCol | input | COL_W | Column address for a read or write |
| cmdError | output | 1 | One-cycle pulse after a rejected command |
| rowOpen | output | 1 | Bank has an open row |
| openRow | output | ROW_W | Row held open in the bank |
| rdValid | output | 1 | A read data word is on the bus this cycle |
| rdCol | output | COL_W | Column of the word on the bus |

## Verification
The properties assume that `cmdOp` is driven once per cycle, is settled at the sampling edge, and only changes away from it. They also assume the configuration inputs do not matter outside reset. The bench changes every input on the falling edge and holds the configuration steady throughout each reset. It sweeps the row delay, the row-active time and the CAS latency across small ranges, and within each setting it tries every command spacing around the limit. The expected accept or reject decision and the expected strobe schedule are both computed from cycle arithmetic.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;
  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_RD  = 3'd2;
  localparam logic [2:0] OP_WR  = 3'd3;
  localparam logic [2:0] OP_PRE = 3'd4;
  localparam logic [2:0] OP_BST = 3'd5;

  // Strobes from the bank-control half to the read-return half.
  typedef struct packed {
    logic doRead;   // a read was accepted this cycle
    logic doStop;   // a burst stop arrived this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/sdram_bank_ctrl.sv
module sdram_bank_ctrl
  import sdram_sched_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int TW    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TW-1:0]    cfgRcd,
  input  logic [TW-1:0]    cfgRas,
  input  logic [2:0]       cmdOp,
  input  logic [ROW_W-1:0] cmdRow,
  output ctrlStrobe_t      strobe,
  output logic             cmdError,
  output logic             rowOpen,
  output logic [ROW_W-1:0] openRow
);
  logic [TW-1:0] rcdLim, rasLim;
  logic [TW-1:0] rcdLeft, rasLeft;
  logic isAct, isRd, isWr, isPre, isBst;
  logic colOk, preOk, illegal;

  always_comb begin
    isAct = (cmdOp == OP_ACT);
    isRd  = (cmdOp == OP_RD);
    isWr  = (cmdOp == OP_WR);
    isPre = (cmdOp == OP_PRE);
    isBst = (cmdOp == OP_BST);
    colOk = rowOpen && (rcdLeft == '0);
    preOk = rowOpen && (rasLeft == '0);
    illegal = (isAct && rowOpen)
            || ((isRd || isWr) && !colOk)
            || (isPre && !preOk);
    strobe.doRead = isRd && colOk;
    strobe.doStop = isBst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      // limits of zero behave as one cycle
      rcdLim   <= (cfgRcd == '0) ? TW'(1) : cfgRcd;
      rasLim   <= (cfgRas == '0) ? TW'(1) : cfgRas;
      rcdLeft  <= '0;
      rasLeft  <= '0;
      rowOpen  <= 1'b0;
      openRow  <= '0;
      cmdError <= 1'b0;
    end else begin
      cmdError <= illegal;
      if (isAct && !rowOpen) begin
        rowOpen <= 1'b1;
        openRow <= cmdRow;
        rcdLeft <= rcdLim - TW'(1);
        rasLeft <= rasLim - TW'(1);
      end else begin
        if (rcdLeft != '0) rcdLeft <= rcdLeft - TW'(1);
        if (rasLeft != '0) rasLeft <= rasLeft - TW'(1);
        if (isPre && preOk) rowOpen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_read_return.sv
module sdram_read_return
  import sdram_sched_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int BL     = 2,
  parameter int MAX_CL = 3,
  parameter int TW     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TW-1:0]    cfgCas,
  input  ctrlStrobe_t      strobe,
  input  logic [COL_W-1:0] cmdCol,
  output logic             rdValid,
  output logic [COL_W-1:0] rdCol
);
  localparam int LINE   = MAX_CL - 1;
  localparam int IDX_W  = (LINE > 1) ? $clog2(LINE) : 1;
  localparam int BEAT_W = (BL > 1) ? $clog2(BL) : 1;

  logic [TW-1:0]    clLat;
  logic [LINE-1:0]  tokV;
  logic [COL_W-1:0] tokCol [LINE];
  logic [IDX_W-1:0] tapIdx;
  logic             tapV;
  logic [COL_W-1:0] tapCol;
  logic [COL_W-1:0] baseCol;
  logic [BEAT_W-1:0] beat, beatLeft, lowCol;

  assign tapIdx = IDX_W'(clLat - TW'(2));
  assign tapV   = tokV[tapIdx];
  assign tapCol = tokCol[tapIdx];
  assign lowCol = baseCol[BEAT_W-1:0] + beat;
  assign rdCol  = {baseCol[COL_W-1:BEAT_W], lowCol};

  // Delay line: stage k holds a read accepted k+1 cycles ago.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clLat <= (cfgCas < TW'(2)) ? TW'(2) :
               (cfgCas > TW'(MAX_CL)) ? TW'(MAX_CL) : cfgCas;
      tokV  <= '0;
      for (int k = 0; k < LINE; k++) tokCol[k] <= '0;
    end else if (strobe.doStop) begin
      tokV <= '0;
    end else begin
      tokV[0]   <= strobe.doRead;
      tokCol[0] <= cmdCol;
      for (int k = 1; k < LINE; k++) begin
        tokV[k]   <= tokV[k-1];
        tokCol[k] <= tokCol[k-1];
      end
    end
  end

  // Burst engine: a fresh start always replaces the running burst.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      baseCol  <= '0;
      beat     <= '0;
      beatLeft <= '0;
    end else if (strobe.doStop) begin
      rdValid  <= 1'b0;
      beatLeft <= '0;
    end else if (tapV) begin
      rdValid  <= 1'b1;
      baseCol  <= tapCol;
      beat     <= '0;
      beatLeft <= BEAT_W'(BL - 1);
    end else if (beatLeft != '0) begin
      rdValid  <= 1'b1;
      beat     <= beat + BEAT_W'(1);
      beatLeft <= beatLeft - BEAT_W'(1);
    end else begin
      rdValid  <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_bank_sched.sv
module sdram_bank_sched
  import sdram_sched_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int BL     = 2,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       cfgRcd,
  input  logic [3:0]       cfgRas,
  input  logic [3:0]       cfgCas,
  input  logic [2:0]       cmdOp,
  input  logic [ROW_W-1:0] cmdRow,
  input  logic [COL_W-1:0] cmdCol,
  output logic             cmdError,
  output logic             rowOpen,
  output logic [ROW_W-1:0] openRow,
  output logic             rdValid,
  output logic [COL_W-1:0] rdCol
);
  ctrlStrobe_t strobe;

  sdram_bank_ctrl #(.ROW_W(ROW_W), .TW(4)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgRcd(cfgRcd), .cfgRas(cfgRas),
    .cmdOp(cmdOp), .cmdRow(cmdRow), .strobe(strobe),
    .cmdError(cmdError), .rowOpen(rowOpen), .openRow(openRow)
  );

  sdram_read_return #(.COL_W(COL_W), .BL(BL), .MAX_CL(MAX_CL), .TW(4)) uData (
    .clk(clk), .rstN(rstN), .cfgCas(cfgCas), .strobe(strobe),
    .cmdCol(cmdCol), .rdValid(rdValid), .rdCol(rdCol)
  );
endmodule

// File: rtl/sdram_bank_sched_chk.sv
module sdram_bank_sched_chk #(
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cmdOp,
  input logic [ROW_W-1:0] cmdRow,
  input logic             cmdError,
  input logic             rowOpen,
  input logic [ROW_W-1:0] openRow,
  input logic             rdValid
);
  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && !rowOpen) |=> (rowOpen && !cmdError && openRow == $past(cmdRow)));

  assert_act_on_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && rowOpen) |=> (cmdError && $stable(openRow) && rowOpen));

  assert_closed_bank_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdOp == 3'd2 || cmdOp == 3'd3 || cmdOp == 3'd4) && !rowOpen) |=> (cmdError && !rowOpen));

  assert_nop_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd0 || cmdOp == 3'd6 || cmdOp == 3'd7) |=> !cmdError);

  assert_stop_silences_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd5) |=> !rdValid);

  assert_column_keeps_row_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdOp == 3'd2 || cmdOp == 3'd3) && rowOpen) |=> (rowOpen && $stable(openRow)));
endmodule

bind sdram_bank_sched sdram_bank_sched_chk #(.ROW_W(ROW_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdRow(cmdRow),
  .cmdError(cmdError), .rowOpen(rowOpen), .openRow(openRow), .rdValid(rdValid)
);

// File: tb/sdram_bank_sched_test.sv
module sdram_bank_sched_test;
  localparam int ROW_W = 4, COL_W = 4, BL = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] cfgRcd = 4'd1, cfgRas = 4'd1, cfgCas = 4'd2;
  logic [2:0] cmdOp = 3'd0;
  logic [ROW_W-1:0] cmdRow = '0;
  logic [COL_W-1:0] cmdCol = '0;
  logic cmdError, rowOpen, rdValid;
  logic [ROW_W-1:0] openRow;
  logic [COL_W-1:0] rdCol;

  int checks = 0, fails = 0, cyc = 0;
  bit expV [0:511];
  int expC [0:511];
  bit mOpen;
  int mRow, actCyc, mRcd, mRas, mCl;

  sdram_bank_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .BL(BL)) uut (
    .clk(clk), .rstN(rstN), .cfgRcd(cfgRcd), .cfgRas(cfgRas), .cfgCas(cfgCas),
    .cmdOp(cmdOp), .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdError(cmdError),
    .rowOpen(rowOpen), .openRow(openRow), .rdValid(rdValid), .rdCol(rdCol)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // R8 / R9: strobe schedule and column order checked every cycle
  always @(negedge clk) begin
    if (rstN) begin
      chk("R8", rdValid, expV[cyc]);
      if (expV[cyc]) chk("R9", rdCol, expC[cyc]);
    end
  end

  task automatic doReset(int rcd, int ras, int cas);
    @(negedge clk);
    rstN = 1'b0;
    cmdOp = 3'd0;
    cfgRcd = 4'(rcd); cfgRas = 4'(ras); cfgCas = 4'(cas);
    for (int i = 0; i < 512; i++) begin expV[i] = 1'b0; expC[i] = 0; end
    mOpen = 1'b0; mRow = 0; actCyc = 0;
    mRcd = (rcd == 0) ? 1 : rcd;
    mRas = (ras == 0) ? 1 : ras;
    mCl  = (cas < 2) ? 2 : (cas > 3) ? 3 : cas;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1", rowOpen, 0);
    chk("R1", rdValid, 0);
    chk("R1", cmdError, 0);
  endtask

  // Issue one command at the current falling edge; checks land one cycle later.
  task automatic step(string req, int op, int row, int col);
    int c;
    bit ill;
    c = cyc;
    case (op)
      1: ill = mOpen;
      2, 3: ill = !mOpen || ((c - actCyc) < mRcd);
      4: ill = !mOpen || ((c - actCyc) < mRas);
      default: ill = 1'b0;
    endcase
    if (!ill) begin
      if (op == 1) begin mOpen = 1'b1; mRow = row; actCyc = c; end
      if (op == 4) mOpen = 1'b0;
      if (op == 2) begin
        for (int x = c + mCl; x < 512; x++) expV[x] = 1'b0;
        for (int i = 0; i < BL; i++) begin
          expV[c + mCl + i] = 1'b1;
          expC[c + mCl + i] = (col & ~(BL - 1)) | ((col + i) % BL);
        end
      end
      if (op == 5) for (int x = c + 1; x < 512; x++) expV[x] = 1'b0;
    end
    cmdOp = 3'(op); cmdRow = ROW_W'(row); cmdCol = COL_W'(col);
    @(posedge clk);
    @(negedge clk);
    cmdOp = 3'd0;
    chk(req, cmdError, ill);
    chk(req, rowOpen, mOpen);
    if (mOpen) chk(req, openRow, mRow);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step("R7", 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R4 with R1 CAS mapping: column access spacing after activate
    for (int rcd = 0; rcd <= 4; rcd++)
      for (int ci = 0; ci < 3; ci++)
        for (int j = 1; j <= 5; j++) begin
          doReset(rcd, 6, (ci == 0) ? 2 : (ci == 1) ? 3 : 9);
          step("R3", 1, j, 0);
          idle(j - 1);
          step("R4", (j % 2) ? 2 : 3, 0, (j * 3) % 16);
          idle(6);
        end
    // R5: precharge spacing after activate
    for (int ras = 0; ras <= 6; ras++)
      for (int j = 1; j <= 7; j++) begin
        doReset(1, ras, 2);
        step("R3", 1, 7, 0);
        idle(j - 1);
        step("R5", 4, 0, 0);
        idle(1);
        step("R5", 1, 2, 0);
      end
    // R6, R2, R3, R12: bank state rules
    doReset(2, 3, 3);
    step("R6", 2, 0, 1);
    idle(4);
    step("R6", 3, 0, 1);
    step("R6", 4, 0, 0);
    step("R11", 5, 0, 0);
    step("R2", 6, 0, 0);
    step("R2", 7, 0, 0);
    step("R3", 1, 9, 0);
    step("R3", 1, 3, 0);
    idle(2);
    step("R12", 2, 5, 6);
    step("R12", 3, 4, 11);
    idle(5);
    // R10: back-to-back and overlapping reads, CAS 3
    doReset(1, 1, 3);
    step("R3", 1, 2, 0);
    idle(1);
    step("R10", 2, 0, 5);
    idle(1);
    step("R10", 2, 0, 2);
    step("R10", 2, 0, 8);
    step("R10", 2, 0, 15);
    idle(8);
    // R10 with CAS 2 and reads spaced by the burst length
    doReset(1, 1, 2);
    step("R3", 1, 4, 0);
    step("R10", 2, 0, 3);
    idle(1);
    step("R10", 2, 0, 12);
    idle(6);
    // R11: burst stop before data and in mid-burst
    doReset(1, 1, 2);
    step("R3", 1, 1, 0);
    step("R11", 2, 0, 1);
    step("R11", 5, 0, 0);
    idle(4);
    step("R11", 2, 0, 6);
    idle(1);
    step("R11", 5, 0, 0);
    idle(4);
    doReset(1, 1, 3);
    step("R3", 1, 1, 0);
    step("R11", 2, 0, 9);
    idle(3);
    step("R11", 5, 0, 0);
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule